// File: doc/BRIEF.md
# Three-Channel LED Pulse-Width Modulator

This block produces the on/off enables for three LED current sinks. A single free-running period counter, advanced only on a prescale strobe, is shared by all three channels. Each channel compares the counter with its own active duty value and so sets the fraction of every period during which its LED conducts. The width of the duty values is a parameter and defaults to 5 bits, which gives 32 levels, from fully dark to continuously lit.

Duty values come from the command receiver and may change at any moment. A channel copies its input into its active duty value only when the counter wraps, so each period is driven by one duty value from start to end. Two conditions force every output low: the device is shut down, or the programmed current step is zero. The current amplitude itself is handled elsewhere.

Top module: `rgb_pwm_core`

## Requirements
- R1: After reset every `led_on` bit is 0, the period counter is 0 and every active duty value is 0. Until the first counter wrap the outputs stay 0, whatever duty is applied.
- R2: A channel whose active duty is 0 keeps its `led_on` bit at 0 for the whole period.
- R3: A channel whose active duty is the all-ones value (31) keeps its `led_on` bit at 1 for every count of the period, including count 31. This gives 100% duty, not 31/32.
- R4: For an active duty d with 1 <= d <= 30, a channel's `led_on` bit is 1 in the clock cycle after one in which the period count is below d, and 0 otherwise. This makes d/32 of the period high.
- R5: When `run_en` is 0 in a cycle, every `led_on` bit is 0 in the following cycle.
- R6: When `cur_step` is 0 in a cycle, every `led_on` bit is 0 in the following cycle.
- R7: A channel's active duty takes the value on `duty_vec` only in a cycle where `tick` is 1 and the count is 31, so it takes effect from count 0. Changes at any other time have no effect on the current period.
- R8: The period counter advances by one, modulo 32, on each cycle with `tick` = 1 and holds on every other cycle.
- R9: The channels are independent. Channel i takes its duty from `duty_vec[5*i+4:5*i]` (red = 0, green = 1, blue = 2) and drives only `led_on[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescale strobe that advances the period counter |
| run_en | input | 1 | 1 = running, 0 = shut down |
| cur_step | input | 5 | Programmed current step; zero forces outputs off |
| duty_vec | input | 15 | Packed duty values, channel i at bits 5*i+4 to 5*i |
| led_on | output | 3 | Registered current-sink enables, one per channel |

## Verification
The case that is hardest to reach from the ports is a duty value that changes in the middle of a period, and in particular one that changes just before or on the wrap cycle. That case must show whether the old value is kept to the end of the period and the new one picked up exactly at count 0. The stimulus uses an irregular tick pattern and rewrites each channel's duty on its own at random cycles. This puts writes on the wrap cycle, one cycle before it and mid-period, and during stretches with no tick. A scoreboard model tracks the count and the pending and active duties and predicts every output bit in every cycle.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;

  // Compare rule for one channel: all-ones duty is a full period, else count < duty
  function automatic logic pwm_level(input logic [4:0] count, input logic [4:0] duty);
    logic full;
    full = &duty;
    return full | (count < duty);
  endfunction

  // Next value of the period counter
  function automatic logic [4:0] count_next(input logic [4:0] count, input logic adv);
    return adv ? 5'(count + 5'd1) : count;
  endfunction

endpackage

// File: rtl/rgbpwm_period_ctr.sv
module rgbpwm_period_ctr
  import rgbpwm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_next(count, tick);
  end

  // period boundary: the strobe that moves the count from LAST back to zero
  assign wrap = tick && (count == LAST);
endmodule

// File: rtl/rgbpwm_channel.sv
module rgbpwm_channel
  import rgbpwm_pkg::*;
#(
  parameter int DUTY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [DUTY_W-1:0] count,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [DUTY_W-1:0] active_duty,
  output logic              raw_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_duty <= '0;
    else if (wrap) active_duty <= duty_in;
  end

  assign raw_on = pwm_level(count, active_duty);
endmodule

// File: rtl/rgbpwm_gate.sv
module rgbpwm_gate #(
  parameter int CHANNELS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                allow,
  input  logic [CHANNELS-1:0] raw_on,
  output logic [CHANNELS-1:0] led_on
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_on <= '0;
    else        led_on <= allow ? raw_on : '0;
  end
endmodule

// File: rtl/rgb_pwm_core.sv
module rgb_pwm_core #(
  parameter int CHANNELS = 3,
  parameter int DUTY_W   = 5,
  parameter int STEP_W   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       run_en,
  input  logic [STEP_W-1:0]          cur_step,
  input  logic [CHANNELS*DUTY_W-1:0] duty_vec,
  output logic [CHANNELS-1:0]        led_on
);
  logic [DUTY_W-1:0]          period_count;
  logic                       period_wrap;
  logic [CHANNELS*DUTY_W-1:0] active_duty_vec;
  logic [CHANNELS-1:0]        raw_on;
  logic                       sink_allow;

  rgbpwm_period_ctr #(.CNT_W(DUTY_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .count(period_count), .wrap(period_wrap)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    rgbpwm_channel #(.DUTY_W(DUTY_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wrap(period_wrap), .count(period_count),
      .duty_in(duty_vec[ch*DUTY_W +: DUTY_W]),
      .active_duty(active_duty_vec[ch*DUTY_W +: DUTY_W]),
      .raw_on(raw_on[ch])
    );
  end

  assign sink_allow = run_en && (cur_step != '0);

  rgbpwm_gate #(.CHANNELS(CHANNELS)) u_gate (
    .clk(clk), .rst_n(rst_n), .allow(sink_allow),
    .raw_on(raw_on), .led_on(led_on)
  );
endmodule

// File: rtl/rgb_pwm_core_chk.sv
module rgb_pwm_core_chk #(
  parameter int CHANNELS = 3,
  parameter int DUTY_W   = 5,
  parameter int STEP_W   = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       run_en,
  input logic [STEP_W-1:0]          cur_step,
  input logic [CHANNELS-1:0]        led_on,
  input logic [DUTY_W-1:0]          period_count,
  input logic                       period_wrap,
  input logic [CHANNELS*DUTY_W-1:0] active_duty_vec
);
  assert_shutdown_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (led_on == '0));

  assert_step_zero_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step == '0) |=> (led_on == '0));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(period_count));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (period_count == DUTY_W'($past(period_count) + 1'b1)));

  assert_duty_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(active_duty_vec));

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chk
    assert_full_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && cur_step != '0 && (&active_duty_vec[ch*DUTY_W +: DUTY_W]))
      |=> led_on[ch]);

    assert_zero_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active_duty_vec[ch*DUTY_W +: DUTY_W] == '0) |=> !led_on[ch]);
  end
endmodule

bind rgb_pwm_core rgb_pwm_core_chk #(
  .CHANNELS(CHANNELS), .DUTY_W(DUTY_W), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .cur_step(cur_step),
  .led_on(led_on), .period_count(period_count), .period_wrap(period_wrap),
  .active_duty_vec(active_duty_vec)
);

// File: tb/rgb_pwm_core_test.sv
module rgb_pwm_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        run_en = 1'b0;
  logic [4:0]  cur_step = 5'd0;
  logic [14:0] duty_vec = '0;
  logic [2:0]  led_on;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R1";

  typedef struct { logic [2:0] exp; string tag; } item_t;
  item_t sb_q[$];

  // bench-side model
  int m_cnt = 0;
  int m_act[3] = '{0, 0, 0};

  always #4 clk = ~clk;

  rgb_pwm_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
    .cur_step(cur_step), .duty_vec(duty_vec), .led_on(led_on)
  );

  function automatic int field(input logic [14:0] v, input int ch);
    return int'(v[ch*5 +: 5]);
  endfunction

  // Drive one cycle at the falling edge and predict the output after the next rise
  task automatic drive(input bit tk, input bit en, input int step, input logic [14:0] dv);
    item_t it;
    @(negedge clk);
    tick = tk; run_en = en; cur_step = 5'(step); duty_vec = dv;
    for (int c = 0; c < 3; c++) begin
      bit lit;
      if (m_act[c] == 31) lit = 1;          // R3 full period
      else lit = (m_cnt < m_act[c]);        // R4 / R2
      it.exp[c] = en && (step != 0) && lit;
    end
    if (!en) it.tag = "R5";
    else if (step == 0) it.tag = "R6";
    else if (field(dv,0) != m_act[0] || field(dv,1) != m_act[1] || field(dv,2) != m_act[2])
      it.tag = "R7";
    else if (m_act[0] == 31 || m_act[1] == 31 || m_act[2] == 31) it.tag = "R3";
    else if (m_act[0] == 0 || m_act[1] == 0 || m_act[2] == 0) it.tag = "R2";
    else it.tag = "R4";
    it.tag = {it.tag, "/", phase};
    sb_q.push_back(it);
    if (tk) begin
      if (m_cnt == 31) for (int c = 0; c < 3; c++) m_act[c] = field(dv, c);
      m_cnt = (m_cnt + 1) % 32;   // R8
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      vectors++;
      if (led_on !== it.exp) begin
        errors++;
        $display("FAIL %s: led_on=%b expected=%b at %0t", it.tag, led_on, it.exp, $time);
      end
    end
  end

  task automatic run_regular(input int cycles, input int div, input bit en,
                             input int step, input logic [14:0] dv);
    for (int k = 0; k < cycles; k++) drive((k % div) == 0, en, step, dv);
  endtask

  initial begin
    logic [14:0] dv;
    #1;
    // R1: reset state
    @(negedge clk);
    vectors++;
    if (led_on !== 3'b000) begin
      errors++; $display("FAIL R1: led_on=%b expected=000", led_on);
    end
    rst_n = 1'b1;
    // R1: before the first wrap outputs stay low despite nonzero duties
    phase = "R1";
    run_regular(40, 2, 1, 10, {5'd31, 5'd0, 5'd5});
    // R2 R3 R4: red 5, green 0, blue 31
    phase = "R4";
    run_regular(200, 2, 1, 10, {5'd31, 5'd0, 5'd5});
    // R9: channels rewritten independently mid period
    phase = "R9";
    run_regular(37, 3, 1, 7, {5'd31, 5'd1, 5'd30});
    run_regular(150, 3, 1, 7, {5'd17, 5'd1, 5'd30});
    // R5 shutdown then resume
    phase = "R5";
    run_regular(50, 1, 0, 7, {5'd17, 5'd20, 5'd30});
    run_regular(70, 1, 1, 7, {5'd17, 5'd20, 5'd30});
    // R6 zero step
    phase = "R6";
    run_regular(50, 1, 1, 0, {5'd31, 5'd31, 5'd31});
    run_regular(70, 1, 1, 3, {5'd31, 5'd31, 5'd31});
    // R8 R7: irregular ticks and random per-channel rewrites
    phase = "R8";
    dv = {5'd9, 5'd22, 5'd2};
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < 3; c++)
        if ($urandom_range(0, 15) == 0) dv[c*5 +: 5] = 5'($urandom_range(0, 31));
      drive($urandom_range(0, 2) != 0, $urandom_range(0, 40) != 0,
            ($urandom_range(0, 50) == 0) ? 0 : 12, dv);
    end
    @(posedge clk); #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule